// File: doc/BRIEF.md
# Level-Sensitive Fast Interrupt Unit

This block holds the processor-side pending and enable state for a bank of fast interrupt request lines that come from on-chip peripherals. Every line is level-sensitive. A peripheral holds its request high until software acknowledges it through that peripheral's own control register. The pending bit for the line follows the registered request level, in the same way as the standard machine timer interrupt. No one-shot capture or queue sits between the peripheral and the pending bit. As a result, turning an enable bit off and on again never loses a request that is still asserted.

Sixteen line positions exist. Twelve are wired to peripherals: line 0 is the watchdog, and lines 2/3, 4/5 and 10/11 are pairs from single peripherals. Lines 12 to 15 are tied low. A small register port exposes three words:

- a read-only pending word,
- a read/write enable word,
- a control word that holds the global interrupt enable.

From pending, enable and global enable the block derives a trap request with a fixed-priority cause index. It also drives a wake signal for a core that is sleeping in wait-for-interrupt. The wake signal ignores the global enable, and a debug halt request raises it too.

The register port is a plain control interface with no valid/ready handshake. A write takes effect at the clock edge on which the write strobe is high. A read returns data combinationally, so it never applies back-pressure.

Top module: `firq_level_unit`

## Requirements
- R1: During and after reset the enable word and the global enable are zero, and trap_req_o and wake_o are low while no debug halt is present.
- R2: Address 0 (pending) reads the request lines as they were sampled at the previous clock edge. Bit i holds line i, and bits 12 to 15 always read 0.
- R3: Writes to address 0 are ignored: the pending word still reads the sampled line levels afterwards.
- R4: Address 1 (enable) is read/write over all 16 bits. Bit i enables line i.
- R5: Clearing an enable bit and then setting it again does not clear a pending request whose line is still high. The trap request returns with the same cause.
- R6: A pending bit clears one clock edge after its line drops, and never earlier while the line stays high.
- R7: trap_req_o is high exactly when the global enable is set and at least one line is both pending and enabled.
- R8: While trap_req_o is high, trap_cause_o equals the lowest index that is both pending and enabled. Otherwise it is 0.
- R9: wake_o is high when any line is both pending and enabled, whatever the global enable, or when dbg_halt_i is high.
- R10: Address 2 (control) holds the global enable in bit 0, which is read/write. Its other bits read 0. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| irq_lines_i | input | 12 | Level-sensitive peripheral request lines |
| dbg_halt_i | input | 1 | Debug halt request, used only for wake-up |
| csr_we_i | input | 1 | Register write strobe |
| csr_addr_i | input | 2 | Register word select |
| csr_wdata_i | input | 16 | Register write data |
| csr_rdata_o | output | 16 | Register read data, combinational |
| trap_req_o | output | 1 | Trap request to the core |
| trap_cause_o | output | 4 | Index of the highest-priority active line |
| wake_o | output | 1 | Wake request for a sleeping core |

## Verification
A stale or corrupted pending bit shows on the pending read and on the trap outputs one clock after the line changes. That is why every line pattern is applied and then observed exactly one edge later. A lost enable or global enable bit appears at once as a missing trap request or a wrong cause. A stray write into pending state appears on the next read of address 0. The sweep covers all 4096 line patterns under several enable masks, with the global enable both set and clear. Across that sweep, a wrong priority order or a wake term gated by the global enable would produce a mismatch in the same cycle.

// File: rtl/firq_pkg.sv
package firq_pkg;
  localparam int unsigned FIRQ_LINES = 16;
  localparam int unsigned FIRQ_IDX_W = $clog2(FIRQ_LINES);

  typedef enum logic [1:0] {
    REG_PEND = 2'd0,
    REG_EN   = 2'd1,
    REG_CTRL = 2'd2,
    REG_VOID = 2'd3
  } firq_reg_e;
endpackage

// File: rtl/firq_in_sync.sv
module firq_in_sync #(
  parameter int unsigned NUM_LINES = 16,
  parameter int unsigned NUM_USED  = 12
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_USED-1:0]  lines_i,
  output logic [NUM_LINES-1:0] pend_o
);
  logic [NUM_USED-1:0] sample_q;

  // single register stage; the pending bit is the live level, one edge late
  always_ff @(posedge clk_i) begin
    if (!rst_ni) sample_q <= '0;
    else         sample_q <= lines_i;
  end

  generate
    if (NUM_USED < NUM_LINES) begin : g_pad
      assign pend_o = {{(NUM_LINES - NUM_USED){1'b0}}, sample_q};
    end else begin : g_full
      assign pend_o = sample_q;
    end
  endgenerate

  // R6: a line held high keeps its pending bit set
  generate
    for (genvar i = 0; i < NUM_USED; i++) begin : g_chk
      p_hold_while_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lines_i[i] |=> pend_o[i]);
    end
  endgenerate
endmodule

// File: rtl/firq_csr_regs.sv
module firq_csr_regs
  import firq_pkg::*;
#(
  parameter int unsigned NUM_LINES = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  firq_reg_e            addr_i,
  input  logic [NUM_LINES-1:0] wdata_i,
  output logic [NUM_LINES-1:0] en_o,
  output logic                 gie_o
);
  logic [NUM_LINES-1:0] en_q;
  logic                 gie_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      en_q  <= '0;
      gie_q <= 1'b0;
    end else if (we_i) begin
      if (addr_i == REG_EN)   en_q  <= wdata_i;
      if (addr_i == REG_CTRL) gie_q <= wdata_i[0];
    end
  end

  assign en_o  = en_q;
  assign gie_o = gie_q;

  // R4: the enable word changes only through a write to its own address
  p_en_only_by_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == REG_EN) |=> $stable(en_q));
  // R10: the global enable changes only through a write to the control word
  p_gie_only_by_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == REG_CTRL) |=> $stable(gie_q));
endmodule

// File: rtl/firq_prio_enc.sv
module firq_prio_enc #(
  parameter int unsigned NUM_LINES = 16,
  localparam int unsigned IDX_W    = $clog2(NUM_LINES)
) (
  input  logic [NUM_LINES-1:0] req_i,
  output logic                 hit_o,
  output logic [IDX_W-1:0]     idx_o
);
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    // walk downward so the lowest set index is the one left behind
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        hit_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/firq_level_unit.sv
module firq_level_unit
  import firq_pkg::*;
#(
  parameter int unsigned NUM_LINES = FIRQ_LINES,
  parameter int unsigned NUM_USED  = 12,
  localparam int unsigned IDX_W    = $clog2(NUM_LINES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_USED-1:0]  irq_lines_i,
  input  logic                 dbg_halt_i,
  input  logic                 csr_we_i,
  input  logic [1:0]           csr_addr_i,
  input  logic [NUM_LINES-1:0] csr_wdata_i,
  output logic [NUM_LINES-1:0] csr_rdata_o,
  output logic                 trap_req_o,
  output logic [IDX_W-1:0]     trap_cause_o,
  output logic                 wake_o
);
  firq_reg_e            sel;
  logic [NUM_LINES-1:0] pend;
  logic [NUM_LINES-1:0] en;
  logic                 gie;
  logic [NUM_LINES-1:0] active;
  logic                 any_active;
  logic [IDX_W-1:0]     first_idx;

  assign sel = firq_reg_e'(csr_addr_i);

  firq_in_sync #(.NUM_LINES(NUM_LINES), .NUM_USED(NUM_USED)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lines_i (irq_lines_i),
    .pend_o  (pend)
  );

  firq_csr_regs #(.NUM_LINES(NUM_LINES)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (csr_we_i),
    .addr_i  (sel),
    .wdata_i (csr_wdata_i),
    .en_o    (en),
    .gie_o   (gie)
  );

  assign active = pend & en;

  firq_prio_enc #(.NUM_LINES(NUM_LINES)) u_prio (
    .req_i (active),
    .hit_o (any_active),
    .idx_o (first_idx)
  );

  assign trap_req_o   = gie & any_active;
  assign trap_cause_o = trap_req_o ? first_idx : '0;
  assign wake_o       = any_active | dbg_halt_i;

  always_comb begin
    unique case (sel)
      REG_PEND: csr_rdata_o = pend;
      REG_EN:   csr_rdata_o = en;
      REG_CTRL: csr_rdata_o = {{(NUM_LINES - 1){1'b0}}, gie};
      default:  csr_rdata_o = '0;
    endcase
  end

  // R7: no trap request without the global enable
  p_trap_needs_gie_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_req_o |-> gie);
  // R8: the reported cause is a line that is both pending and enabled
  p_cause_is_active_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_req_o |-> (pend[trap_cause_o] && en[trap_cause_o]));
  // R8: no lower-numbered line is active
  p_cause_lowest_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_req_o |-> ((active & ((NUM_LINES'(1) << trap_cause_o) - NUM_LINES'(1))) == '0));
  // R9: a debug halt always wakes the core
  p_dbg_wakes_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_halt_i |-> wake_o);
  // R9: an enabled pending line wakes the core even with the global enable clear
  p_active_wakes_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(pend & en)) |-> wake_o);
  // R2: unconnected lines never show as pending
  p_unused_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend >> NUM_USED) == '0);
endmodule

// File: tb/firq_level_unit_test.sv
`timescale 1ns/1ps
module firq_level_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] lines = '0;
  logic        dbg = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        trap;
  logic [3:0]  cause;
  logic        wake;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  firq_level_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .irq_lines_i(lines), .dbg_halt_i(dbg),
    .csr_we_i(we), .csr_addr_i(addr), .csr_wdata_i(wdata), .csr_rdata_o(rdata),
    .trap_req_o(trap), .trap_cause_o(cause), .wake_o(wake)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    addr = a;
    #0.5;
    d = rdata;
  endtask

  task automatic drive(input logic [11:0] v);
    @(negedge clk);
    lines = v;
    @(negedge clk);
  endtask

  function automatic logic [3:0] lowest(input logic [15:0] v);
    for (int i = 15; i >= 0; i--) if (v[i]) lowest = 4'(i);
    if (v == 0) lowest = 4'd0;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected<=150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    logic [15:0] ens [4];
    ens[0] = 16'hFFFF; ens[1] = 16'h0A5A; ens[2] = 16'hF800; ens[3] = 16'h0000;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1 trap in reset", trap, 0);
    chk("R1 wake in reset", wake, 0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(2'd1, d); chk("R1 enable after reset", d, 0);
    rd(2'd2, d); chk("R1 gie after reset", d, 0);
    chk("R1 trap after reset", trap, 0);

    // R4 / R10 readback
    wr(2'd1, 16'hBEEF); rd(2'd1, d); chk("R4 enable readback", d, 16'hBEEF);
    wr(2'd2, 16'hFFFF); rd(2'd2, d); chk("R10 ctrl readback", d, 16'h0001);
    rd(2'd3, d); chk("R10 void address", d, 0);
    wr(2'd2, 16'h0000); rd(2'd2, d); chk("R10 gie clear", d, 0);

    // sweep: R2 R7 R8 R9
    for (int g = 0; g < 2; g++) begin
      wr(2'd2, 16'(g));
      for (int e = 0; e < 4; e++) begin
        wr(2'd1, ens[e]);
        for (int p = 0; p < 4096; p++) begin
          logic [15:0] act;
          drive(12'(p));
          act = {4'd0, 12'(p)} & ens[e];
          rd(2'd0, d);
          chk("R2 pending level", d, {4'd0, 12'(p)});
          chk("R7 trap request", trap, (g == 1) && (act != 0));
          chk("R8 cause", cause, ((g == 1) && (act != 0)) ? lowest(act) : 4'd0);
          chk("R9 wake", wake, act != 0);
        end
      end
    end

    // R3 pending is read-only
    wr(2'd1, 16'h0000);
    drive(12'h123);
    wr(2'd0, 16'hFFFF);
    rd(2'd0, d); chk("R3 write to pending ignored", d, 16'h0123);
    wr(2'd0, 16'h0000);
    rd(2'd0, d); chk("R3 clear write ignored", d, 16'h0123);

    // R5 enable toggle keeps pending
    wr(2'd2, 16'h0001);
    drive(12'h008);
    wr(2'd1, 16'h0008);
    chk("R5 trap before toggle", trap, 1);
    wr(2'd1, 16'h0000);
    chk("R5 trap while disabled", trap, 0);
    rd(2'd0, d); chk("R5 pending while disabled", d, 16'h0008);
    wr(2'd1, 16'h0008);
    chk("R5 trap after re-enable", trap, 1);
    chk("R5 cause after re-enable", cause, 3);

    // R6 clears one edge after the line drops
    @(negedge clk); lines = 12'h000;
    rd(2'd0, d); chk("R6 still pending before edge", d, 16'h0008);
    @(negedge clk);
    rd(2'd0, d); chk("R6 cleared after edge", d, 0);
    chk("R6 trap gone", trap, 0);

    // R9 debug halt wake
    wr(2'd2, 16'h0000);
    @(negedge clk); dbg = 1'b1; #0.5;
    chk("R9 debug wake", wake, 1);
    chk("R9 debug no trap", trap, 0);
    @(negedge clk); dbg = 1'b0; #0.5;
    chk("R9 wake released", wake, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule